// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block is a synthesizable storage core that moves four data words for every access. It runs from one system clock. Each clock cycle carries two data words, a "rise" word and a "fall" word, which stand in for the two edges of a true double-data-rate bus. A request gives a word address. The core expands that address into a four-word burst inside its aligned group of four. The burst starts at the word the low address bits select and wraps around within the group.

Writes take active-low lane enables for every data word. On the 8-bit organisation the lanes are 4-bit nibbles; on the other organisations they are 9-bit lanes. A read issued in the first free slot after a write sees the write's data, including its last two words, which have not yet reached the array. Lanes that the write masked keep their old contents. Requests can be accepted at most every other cycle. A request that arrives while a burst is still using the data bus is dropped, and an error pulse flags it.

Top module: `quad_burst_sram`

## Requirements
- R1: A write accepted in cycle 0 takes its four data words as follows: burst words 0 and 1 on `wr_rise_data`/`wr_fall_data` in cycle 1, and burst words 2 and 3 on the same pins in cycle 2.
- R2: When `DATA_W` is 18 or 36, burst word b goes to word address {`req_addr`[ADDR_W-1:2], (`req_addr`[1:0] + b) mod 4}. Example: a start of 2'b10 visits 10, 11, 00, 01.
- R3: When `DATA_W` is 8 or 9, `req_addr`[1:0] is ignored and burst word b always goes to word b of the group.
- R4: The lane enables are active low. Enable bit l covers data bits [9l+8:9l] on the 9/18/36-bit organisations. A lane whose enable is 1 keeps its stored value.
- R5: `wr_rise_en_n` qualifies burst words 0 and 2, and `wr_fall_en_n` qualifies burst words 1 and 3. The enables are sampled separately for every word.
- R6: When `DATA_W` is 8, two nibble enables replace the lane enables: bit 0 gates data bits [3:0] and bit 1 gates bits [7:4].
- R7: For a read accepted in cycle 0, burst words 0 and 1 appear on `rd_rise_data`/`rd_fall_data` in cycle 2 and words 2 and 3 appear in cycle 3. `rd_valid` is high in both cycles and low otherwise.
- R8: A read accepted in cycle 2 after a write accepted in cycle 0 returns the newly written words of the same group. This includes words 2 and 3, which are still on the write bus.
- R9: In that forwarded read, lanes the write masked return the array's old contents and enabled lanes return the new data.
- R10: A request in the cycle right after an accepted request is ignored: it neither writes nor reads. `req_err` is high in the next cycle.
- R11: While reset is held, and in the first cycles after it, `rd_valid` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Word address; the low two bits give the burst start |
| wr_rise_data | input | DATA_W | Write word for burst words 0 and 2 |
| wr_fall_data | input | DATA_W | Write word for burst words 1 and 3 |
| wr_rise_en_n | input | LANES | Active-low lane enables for the rise word |
| wr_fall_en_n | input | LANES | Active-low lane enables for the fall word |
| rd_rise_data | output | DATA_W | Read word for burst words 0 and 2 |
| rd_fall_data | output | DATA_W | Read word for burst words 1 and 3 |
| rd_valid | output | 1 | Marks a cycle that carries a read word pair |
| req_err | output | 1 | Pulses one cycle after a dropped request |

## Verification
Counting from a request in cycle 0, write data is driven in cycles 1 and 2. Read words are due in cycles 2 and 3, and a dropped request raises `req_err` in cycle 1. The bench drives inputs on the falling edge and samples outputs on the falling edge of exactly those cycles. It also checks that `rd_valid` is low in cycle 1 and in cycle 4. The forwarding tasks issue the read in the same cycle as write words 2 and 3, so the merge path is exercised in its one reachable timing slot. Expected words come from a bench-side memory updated by the lane rules.

// File: rtl/qb_pkg.sv
package qb_pkg;
  // lane width: nibbles for the 8-bit organisation, 9-bit lanes otherwise
  function automatic int lane_width(input int dw);
    return (dw == 8) ? 4 : 9;
  endfunction

  function automatic int lane_count(input int dw);
    return dw / lane_width(dw);
  endfunction

  localparam int BURST_LEN = 4;
endpackage

// File: rtl/qb_burst_seq.sv
module qb_burst_seq #(
  parameter bit HAS_START = 1'b1
) (
  input  logic [1:0] start,
  output logic [7:0] order
);
  genvar b;
  for (b = 0; b < qb_pkg::BURST_LEN; b++) begin : g_beat
    if (HAS_START) begin : g_linear
      assign order[2*b +: 2] = start + 2'(b);
    end else begin : g_fixed
      assign order[2*b +: 2] = 2'(b);
    end
  end
endmodule

// File: rtl/qb_lane_merge.sv
module qb_lane_merge #(
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [LANES-1:0]  en_n,
  output logic [DATA_W-1:0] merged
);
  genvar l;
  for (l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = en_n[l] ? old_word[l*LANE_W +: LANE_W]
                                                : new_word[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/qb_ctrl.sv
module qb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic acc_wr,
  output logic acc_rd,
  output logic wr_ph1,
  output logic wr_ph2,
  output logic rd_ph1,
  output logic rd_ph2,
  output logic req_err
);
  logic busy_q, busy_d;
  logic err_q, err_d;
  logic wp1_q, wp1_d, wp2_q, wp2_d;
  logic rp1_q, rp1_d, rp2_q, rp2_d;

  always_comb begin
    acc_wr = req_valid && !busy_q && req_write;
    acc_rd = req_valid && !busy_q && !req_write;
    busy_d = acc_wr || acc_rd;
    err_d  = req_valid && busy_q;
    wp1_d  = acc_wr;
    wp2_d  = wp1_q;
    rp1_d  = acc_rd;
    rp2_d  = rp1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      wp1_q  <= 1'b0;
      wp2_q  <= 1'b0;
      rp1_q  <= 1'b0;
      rp2_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      wp1_q  <= wp1_d;
      wp2_q  <= wp2_d;
      rp1_q  <= rp1_d;
      rp2_q  <= rp2_d;
    end
  end

  assign wr_ph1  = wp1_q;
  assign wr_ph2  = wp2_q;
  assign rd_ph1  = rp1_q;
  assign rd_ph2  = rp2_q;
  assign req_err = err_q;

  AST_ONE_ACCEPT_PER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr || acc_rd) |=> !(acc_wr || acc_rd)); // R10
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid)); // R10
  AST_WRITE_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ph1, wr_ph2})); // R1
  AST_READ_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ph1, rd_ph2})); // R7
endmodule

// File: rtl/qb_array.sv
module qb_array #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-3:0]     wr_grp,
  input  logic [1:0]            idx_a,
  input  logic [1:0]            idx_b,
  input  logic [DATA_W-1:0]     data_a,
  input  logic [DATA_W-1:0]     data_b,
  input  logic [LANES-1:0]      en_a_n,
  input  logic [LANES-1:0]      en_b_n,
  input  logic [ADDR_W-3:0]     rd_grp,
  output logic [4*DATA_W-1:0]   rd_words
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] old_a, old_b, new_a, new_b;

  assign old_a = mem[{wr_grp, idx_a}];
  assign old_b = mem[{wr_grp, idx_b}];

  qb_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_merge_a (
    .old_word(old_a), .new_word(data_a), .en_n(en_a_n), .merged(new_a));
  qb_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_merge_b (
    .old_word(old_b), .new_word(data_b), .en_n(en_b_n), .merged(new_b));

  always_ff @(posedge clk) begin
    if (we) begin
      mem[{wr_grp, idx_a}] <= new_a;
      mem[{wr_grp, idx_b}] <= new_b;
    end
  end

  genvar k;
  for (k = 0; k < qb_pkg::BURST_LEN; k++) begin : g_rd
    assign rd_words[k*DATA_W +: DATA_W] = mem[{rd_grp, 2'(k)}];
  end

  AST_BEAT_WORDS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (idx_a != idx_b)); // R1
endmodule

// File: rtl/quad_burst_sram.sv
module quad_burst_sram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  localparam int LANE_W = qb_pkg::lane_width(DATA_W),
  localparam int LANES  = qb_pkg::lane_count(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] wr_rise_data,
  input  logic [DATA_W-1:0] wr_fall_data,
  input  logic [LANES-1:0]  wr_rise_en_n,
  input  logic [LANES-1:0]  wr_fall_en_n,
  output logic [DATA_W-1:0] rd_rise_data,
  output logic [DATA_W-1:0] rd_fall_data,
  output logic              rd_valid,
  output logic              req_err
);
  localparam bit HAS_START = (DATA_W >= 18);
  localparam int GRP_W     = ADDR_W - 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic acc_wr, acc_rd, wr_ph1, wr_ph2, rd_ph1, rd_ph2;

  qb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_write(req_write),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .wr_ph1(wr_ph1), .wr_ph2(wr_ph2),
    .rd_ph1(rd_ph1), .rd_ph2(rd_ph2), .req_err(req_err));

  logic [GRP_W-1:0] req_grp;
  assign req_grp = req_addr[ADDR_W-1:2];

  // write address held for the two data cycles
  logic [GRP_W-1:0] wgrp_q, wgrp_d;
  logic [1:0]       wstart_q, wstart_d;
  always_comb begin
    wgrp_d   = wgrp_q;
    wstart_d = wstart_q;
    if (acc_wr) begin
      wgrp_d   = req_grp;
      wstart_d = req_addr[1:0];
    end
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wgrp_q   <= '0;
      wstart_q <= 2'b00;
    end else begin
      wgrp_q   <= wgrp_d;
      wstart_q <= wstart_d;
    end
  end

  logic [7:0] w_order, r_order;
  qb_burst_seq #(.HAS_START(HAS_START)) u_wseq (.start(wstart_q), .order(w_order));
  qb_burst_seq #(.HAS_START(HAS_START)) u_rseq (.start(req_addr[1:0]), .order(r_order));

  logic       arr_we;
  logic [1:0] arr_idx_a, arr_idx_b;
  assign arr_we    = wr_ph1 || wr_ph2;
  assign arr_idx_a = wr_ph2 ? w_order[5:4] : w_order[1:0];
  assign arr_idx_b = wr_ph2 ? w_order[7:6] : w_order[3:2];

  logic [4*DATA_W-1:0] arr_words;
  qb_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_sync_n), .we(arr_we), .wr_grp(wgrp_q),
    .idx_a(arr_idx_a), .idx_b(arr_idx_b), .data_a(wr_rise_data), .data_b(wr_fall_data),
    .en_a_n(wr_rise_en_n), .en_b_n(wr_fall_en_n), .rd_grp(req_grp), .rd_words(arr_words));

  // forwarding of burst words 2 and 3, still on the write bus
  logic [DATA_W-1:0] fwd_w [4];
  logic              same_grp;
  assign same_grp = wr_ph2 && (wgrp_q == req_grp);

  genvar k;
  for (k = 0; k < qb_pkg::BURST_LEN; k++) begin : g_fwd
    logic              hit_r, hit_f;
    logic [LANES-1:0]  sel_en_n;
    logic [DATA_W-1:0] sel_data;
    assign hit_r    = same_grp && (w_order[5:4] == 2'(k));
    assign hit_f    = same_grp && (w_order[7:6] == 2'(k));
    assign sel_en_n = hit_r ? wr_rise_en_n : (hit_f ? wr_fall_en_n : '1);
    assign sel_data = hit_f ? wr_fall_data : wr_rise_data;
    qb_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_fmerge (
      .old_word(arr_words[k*DATA_W +: DATA_W]), .new_word(sel_data),
      .en_n(sel_en_n), .merged(fwd_w[k]));
  end

  // read buffer in burst order
  logic [DATA_W-1:0] rbuf_q [4];
  logic [DATA_W-1:0] rbuf_d [4];
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      rbuf_d[b] = acc_rd ? fwd_w[r_order[2*b +: 2]] : rbuf_q[b];
    end
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int b = 0; b < 4; b++) rbuf_q[b] <= '0;
    end else begin
      for (int b = 0; b < 4; b++) rbuf_q[b] <= rbuf_d[b];
    end
  end

  // output word pairs
  logic [DATA_W-1:0] rise_q, rise_d, fall_q, fall_d;
  logic              valid_q, valid_d;
  always_comb begin
    rise_d  = rise_q;
    fall_d  = fall_q;
    valid_d = 1'b0;
    if (rd_ph1) begin
      rise_d  = rbuf_q[0];
      fall_d  = rbuf_q[1];
      valid_d = 1'b1;
    end else if (rd_ph2) begin
      rise_d  = rbuf_q[2];
      fall_d  = rbuf_q[3];
      valid_d = 1'b1;
    end
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      valid_q <= valid_d;
    end
  end

  assign rd_rise_data = rise_q;
  assign rd_fall_data = fall_q;
  assign rd_valid     = valid_q;

  AST_READ_FIRST_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_rd |=> ##1 rd_valid); // R7
  AST_READ_SECOND_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_rd |=> ##2 rd_valid); // R7
  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_valid |-> ($past(acc_rd, 2) || $past(acc_rd, 3))); // R7
  AST_NO_ACCEPT_DURING_WRITE_DATA1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ph1 |-> !(acc_wr || acc_rd)); // R10
endmodule

// File: tb/quad_burst_sram_test.sv
`timescale 1ns/1ps
module quad_burst_sram_test;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // wide instance (18-bit, two 9-bit lanes)
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [17:0] wrd, wfd, rd_rise, rd_fall;
  logic [1:0]  wre, wfe;
  logic        rd_valid, req_err;

  quad_burst_sram #(.DATA_W(18), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .wr_rise_data(wrd), .wr_fall_data(wfd),
    .wr_rise_en_n(wre), .wr_fall_en_n(wfe), .rd_rise_data(rd_rise),
    .rd_fall_data(rd_fall), .rd_valid(rd_valid), .req_err(req_err));

  // narrow instance (8-bit, nibble lanes)
  logic       n_valid, n_write;
  logic [7:0] n_addr, n_wrd, n_wfd, n_rise, n_fall;
  logic [1:0] n_wre, n_wfe;
  logic       n_rvalid, n_err;

  quad_burst_sram #(.DATA_W(8), .ADDR_W(8)) uut_nib (
    .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_write(n_write),
    .req_addr(n_addr), .wr_rise_data(n_wrd), .wr_fall_data(n_wfd),
    .wr_rise_en_n(n_wre), .wr_fall_en_n(n_wfe), .rd_rise_data(n_rise),
    .rd_fall_data(n_fall), .rd_valid(n_rvalid), .req_err(n_err));

  logic [17:0] ref_mem [256];

  task automatic check(input string what, input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    wrd = '0; wfd = '0; wre = 2'b11; wfe = 2'b11;
  endtask

  task automatic n_idle();
    n_valid = 1'b0; n_write = 1'b0; n_addr = '0;
    n_wrd = '0; n_wfd = '0; n_wre = 2'b11; n_wfe = 2'b11;
  endtask

  function automatic logic [71:0] mk(input int seed);
    logic [71:0] d;
    for (int b = 0; b < 4; b++) d[18*b +: 18] = {6'(seed), 4'(b + 1), 8'(seed * 3 + b)};
    return d;
  endfunction

  // R2 R4 R5: bench-side model of the burst order and lane masks
  task automatic ref_write(input logic [7:0] a, input logic [71:0] d, input logic [7:0] en);
    for (int b = 0; b < 4; b++) begin
      logic [7:0] w;
      w = {a[7:2], 2'(a[1:0] + 2'(b))};
      for (int l = 0; l < 2; l++) begin
        if (!en[2*b + l]) ref_mem[w][9*l +: 9] = d[18*b + 9*l +: 9];
      end
    end
  endtask

  function automatic logic [17:0] ref_word(input logic [7:0] a, input int b);
    return ref_mem[{a[7:2], 2'(a[1:0] + 2'(b))}];
  endfunction

  task automatic drive_beats(input logic [71:0] d, input logic [7:0] en, input int p);
    wrd = d[36*p +: 18];
    wfd = d[36*p + 18 +: 18];
    wre = en[4*p +: 2];
    wfe = en[4*p + 2 +: 2];
  endtask

  // R1: request in cycle 0, words 0/1 in cycle 1, words 2/3 in cycle 2
  task automatic wr_burst(input logic [7:0] a, input logic [71:0] d, input logic [7:0] en,
                          input bit chain, input logic [7:0] ra);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0; drive_beats(d, en, 0);
    @(negedge clk); drive_beats(d, en, 1);
    if (chain) begin req_valid = 1'b1; req_write = 1'b0; req_addr = ra; end
    ref_write(a, d, en);
    if (!chain) begin @(negedge clk); idle(); end
  endtask

  // R7: read requested in the current cycle; words due in cycles 2 and 3
  task automatic rd_collect(input logic [7:0] a, input string tag);
    @(negedge clk); idle();
    check({tag, " rd_valid low in cycle 1"}, 18'(rd_valid), 18'd0);
    @(negedge clk);
    check({tag, " rd_valid cycle 2"}, 18'(rd_valid), 18'd1);
    check({tag, " word 0"}, rd_rise, ref_word(a, 0));
    check({tag, " word 1"}, rd_fall, ref_word(a, 1));
    @(negedge clk);
    check({tag, " rd_valid cycle 3"}, 18'(rd_valid), 18'd1);
    check({tag, " word 2"}, rd_rise, ref_word(a, 2));
    check({tag, " word 3"}, rd_fall, ref_word(a, 3));
    @(negedge clk);
    check({tag, " rd_valid low in cycle 4"}, 18'(rd_valid), 18'd0);
  endtask

  task automatic rd_burst(input logic [7:0] a, input string tag);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    rd_collect(a, tag);
  endtask

  task automatic t_reset();
    idle(); n_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 rd_valid in reset", 18'(rd_valid), 18'd0);
    check("R11 req_err in reset", 18'(req_err), 18'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 rd_valid after reset", 18'(rd_valid), 18'd0);
    check("R11 req_err after reset", 18'(req_err), 18'd0);
  endtask

  task automatic t_basic();
    wr_burst(8'h10, mk(1), 8'h00, 1'b0, 8'h00);
    rd_burst(8'h10, "R1 R7 basic");
  endtask

  task automatic t_order();
    wr_burst(8'h15, mk(2), 8'h00, 1'b0, 8'h00);
    rd_burst(8'h14, "R2 start 00 after write at 01");
    rd_burst(8'h16, "R2 start 10");
    rd_burst(8'h17, "R2 start 11");
  endtask

  task automatic t_masks();
    wr_burst(8'h30, mk(3), 8'h00, 1'b0, 8'h00);
    // word0 lane0 only, word1 lane1 only, word2 lane1 only, word3 lane0 only
    wr_burst(8'h30, mk(4), {2'b10, 2'b01, 2'b01, 2'b10}, 1'b0, 8'h00);
    rd_burst(8'h30, "R4 R5 per-word lane masks");
  endtask

  task automatic t_forward();
    wr_burst(8'h40, mk(5), 8'h00, 1'b0, 8'h00);
    wr_burst(8'h40, mk(6), 8'h00, 1'b1, 8'h40);
    rd_collect(8'h40, "R8 forward full write");
    wr_burst(8'h41, mk(7), {2'b00, 2'b10, 2'b11, 2'b01}, 1'b1, 8'h42);
    rd_collect(8'h42, "R9 forward masked write");
  endtask

  task automatic t_busy();
    logic [71:0] d;
    wr_burst(8'h50, mk(8), 8'h00, 1'b0, 8'h00);
    d = mk(9);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h60;
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h50;
    drive_beats(d, 8'h00, 0);
    check("R10 req_err low for accepted request", 18'(req_err), 18'd0);
    @(negedge clk); req_valid = 1'b0; drive_beats(d, 8'h00, 1);
    check("R10 req_err for dropped request", 18'(req_err), 18'd1);
    ref_write(8'h60, d, 8'h00);
    @(negedge clk); idle();
    check("R10 req_err one cycle only", 18'(req_err), 18'd0);
    rd_burst(8'h50, "R10 dropped write left old data");
    rd_burst(8'h60, "R10 accepted write");
  endtask

  // R3 R6: narrow organisation, nibble lanes, start fixed at word 0
  task automatic t_narrow();
    logic [31:0] d1, d2;
    logic [7:0]  en2;
    logic [7:0]  exp_w [4];
    d1 = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    d2 = {8'h5E, 8'h5D, 8'h5C, 8'h5B};
    en2 = {2'b11, 2'b01, 2'b10, 2'b00};
    exp_w[0] = 8'h5B; exp_w[1] = 8'hAC; exp_w[2] = 8'h52; exp_w[3] = 8'hA3;
    for (int pass = 0; pass < 2; pass++) begin
      logic [31:0] d;
      logic [7:0]  en;
      d  = (pass == 0) ? d1 : d2;
      en = (pass == 0) ? 8'h00 : en2;
      @(negedge clk); n_valid = 1'b1; n_write = 1'b1; n_addr = (pass == 0) ? 8'h20 : 8'h22;
      @(negedge clk); n_valid = 1'b0;
      n_wrd = d[7:0]; n_wfd = d[15:8]; n_wre = en[1:0]; n_wfe = en[3:2];
      @(negedge clk);
      n_wrd = d[23:16]; n_wfd = d[31:24]; n_wre = en[5:4]; n_wfe = en[7:6];
      @(negedge clk); n_idle();
    end
    @(negedge clk); n_valid = 1'b1; n_write = 1'b0; n_addr = 8'h23;
    @(negedge clk); n_idle();
    @(negedge clk);
    check("R6 narrow rd_valid", 18'(n_rvalid), 18'd1);
    check("R3 R6 narrow word 0", 18'(n_rise), 18'(exp_w[0]));
    check("R6 narrow word 1 low nibble only", 18'(n_fall), 18'(exp_w[1]));
    @(negedge clk);
    check("R6 narrow word 2 high nibble only", 18'(n_rise), 18'(exp_w[2]));
    check("R3 narrow word 3 untouched", 18'(n_fall), 18'(exp_w[3]));
  endtask

  initial begin
    t_reset();
    t_basic();
    t_order();
    t_masks();
    t_forward();
    t_busy();
    t_narrow();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule